// File: doc/BRIEF.md
# Interlaced Row-Pair Scan Sequencer for a One-Level 2-D Lifting Wavelet

This block orders the memory traffic of a single-level two-dimensional lifting wavelet transform over an N×N image that sits in an addressable frame buffer. It does not walk the image one row at a time. Each fetch cycle it issues two read addresses: one for the upper row of the current row pair and one for the lower row, both at the same column. It sweeps the columns of that pair from left to right and then moves down to the next unread pair. The two row filters that work in parallel on those two pixels write their results into a transposition buffer. For every fetch, the sequencer hands out the write slot for that pair of results.

The column side reads the buffer back in linear order and emits one slot per cycle. Each slot carries a two-bit sub-band tag and the slot's row and column inside the sub-band. The buffer has 2N entries when the short (5/3) filter is chosen and 4N entries when the long (9/7) filter is chosen. Because it holds only one or two row pairs, fetching the next pair runs alongside the draining of the previous one, and an occupancy count prevents the writes from overtaking the reads. A downstream ready signal freezes the whole sequencer. A one-cycle done pulse marks the end of a frame.

Top module: `irs_ctrl`

## Requirements
- R1: After reset and until a start is accepted, rd_valid, out_valid and done are low.
- R2: In a fetch cycle, rd_addr_a is the linear address (row·N + column) of the pixel at row 2p and column c, where p is the current row pair. rd_addr_b is the address of the pixel at row 2p+1 in the same column, which is rd_addr_a + N.
- R3: A frame performs exactly N·N/2 fetches. Within a row pair, c steps from 0 to N−1. After c = N−1, the next fetch is c = 0 of pair p+1.
- R4: The buffer depth is 2N when mode_wide is 0 and 4N when it is 1. buf_waddr starts at 0 in each frame and advances by 2 after every fetch, wrapping to 0 when it reaches the depth. buf_raddr starts at 0 and advances by 1 after every accepted output, wrapping in the same way.
- R5: The occupancy is 2 × fetches − accepted outputs. It never exceeds the depth. A fetch takes place in every cycle in which out_ready is high, fetches remain, and at least two entries are free.
- R6: out_valid is never high for a slot in sub-band row p before all N fetches of row pair p are complete.
- R7: Outputs are accepted in this order: sub-band row p ascending, then column k from 0 to N/2−1, then tag 0, 1, 2, 3. Tag bit 0 marks horizontal high-pass and tag bit 1 marks vertical high-pass, so LL=0, HL=1, LH=2 and HH=3. out_row is p and out_col is k.
- R8: While out_ready is low, no fetch is issued, the buffer pointers do not move, and a pending output keeps its tag and position.
- R9: done is high for exactly one cycle, in the cycle after the final output is accepted, and the sequencer is idle from that cycle on.
- R10: A start pulse while a frame is running has no effect on the running frame.
- R11: mode_wide is sampled only when a start is accepted. Changing it during a frame does not change the buffer depth in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame; accepted only when idle |
| mode_wide | input | 1 | 0 selects the 2N buffer (5/3), 1 selects the 4N buffer (9/7) |
| out_ready | input | 1 | Downstream accepts the output slot; low stalls everything |
| rd_valid | output | 1 | Fetch this cycle; also the buffer write enable for two entries |
| rd_addr_a | output | clog2(N·N) | Address of the upper-row pixel |
| rd_addr_b | output | clog2(N·N) | Address of the lower-row pixel |
| buf_waddr | output | clog2(4N) | Buffer entry for the upper result; the lower result goes to the next entry |
| buf_raddr | output | clog2(4N) | Buffer entry read for the current output slot |
| out_valid | output | 1 | Output slot available |
| out_band | output | 2 | Sub-band tag |
| out_row | output | clog2(N/2) | Row within the sub-band |
| out_col | output | clog2(N/2) | Column within the sub-band |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A buffer write (a fetch of the next row pair) and a buffer read (an accepted output of the previous pair) can happen in the same cycle. When they do, the occupancy rises by one. This is most visible in 5/3 mode with ready held high, where fetches then alternate with blocked cycles. The bench rebuilds the occupancy from the handshakes it observes. Each cycle it judges whether a fetch was due or forbidden, and it checks the write and read addresses against its own wrapping counters. Ready patterns that are irregular and periodic move the collision points around, and a stray start and a mode flip during a frame test the latching.

// File: rtl/irs_pkg.sv
package irs_pkg;
  typedef enum logic [1:0] {
    BAND_LL = 2'd0,
    BAND_HL = 2'd1,
    BAND_LH = 2'd2,
    BAND_HH = 2'd3
  } band_e;

  // number of transposition entries for the selected filter length
  function automatic int tbuf_depth(input int n, input logic wide);
    return wide ? 4 * n : 2 * n;
  endfunction

  // linear frame-buffer address of a pixel
  function automatic int pix_addr(input int row, input int col, input int n);
    return row * n + col;
  endfunction
endpackage

// File: rtl/irs_fetch_gen.sv
module irs_fetch_gen #(
  parameter  int N  = 16,
  localparam int AW = $clog2(N * N),
  localparam int CW = $clog2(N),
  localparam int PW = $clog2(N / 2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          go,
  output logic          more,
  output logic [PW-1:0] pairs_done,
  output logic [AW-1:0] addr_top,
  output logic [AW-1:0] addr_bot
);
  logic [CW-1:0] col_q;
  logic [PW-1:0] pair_q;
  logic          row_end;

  assign row_end    = (col_q == CW'(N - 1));
  assign more       = (pair_q != PW'(N / 2));
  assign pairs_done = pair_q;
  assign addr_top   = AW'(irs_pkg::pix_addr(2 * int'(pair_q), int'(col_q), N));
  assign addr_bot   = AW'(irs_pkg::pix_addr(2 * int'(pair_q) + 1, int'(col_q), N));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      pair_q <= '0;
    end else if (clear) begin
      col_q  <= '0;
      pair_q <= '0;
    end else if (go) begin
      if (row_end) begin
        col_q  <= '0;
        pair_q <= pair_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irs_tbuf_ptr.sv
module irs_tbuf_ptr #(
  parameter  int N  = 16,
  localparam int BW = $clog2(4 * N),
  localparam int OW = $clog2(4 * N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wide,
  input  logic          push,
  input  logic          pop,
  output logic [BW-1:0] wptr,
  output logic [BW-1:0] rptr,
  output logic [OW-1:0] occ,
  output logic [OW-1:0] depth,
  output logic          room
);
  logic [BW-1:0] wptr_q, rptr_q;
  logic [OW-1:0] occ_q;

  assign depth = OW'(irs_pkg::tbuf_depth(N, wide));
  assign room  = ((OW + 1)'(occ_q) + (OW + 1)'(2)) <= (OW + 1)'(depth);
  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign occ   = occ_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else if (clear) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      if (push)
        wptr_q <= (OW'(wptr_q) + OW'(2) == depth) ? '0 : wptr_q + BW'(2);
      if (pop)
        rptr_q <= (OW'(rptr_q) + OW'(1) == depth) ? '0 : rptr_q + BW'(1);
      occ_q <= occ_q + (push ? OW'(2) : OW'(0)) - (pop ? OW'(1) : OW'(0));
    end
  end
endmodule

// File: rtl/irs_emit_seq.sv
module irs_emit_seq #(
  parameter  int N  = 16,
  localparam int PW = $clog2(N / 2 + 1),
  localparam int EW = $clog2(2 * N),
  localparam int HW = EW - 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic [PW-1:0]    pairs_done,
  input  logic             ready,
  output logic             valid,
  output logic             fire,
  output logic             last,
  output irs_pkg::band_e   band,
  output logic [HW-1:0]    row,
  output logic [HW-1:0]    col
);
  logic [EW-1:0] idx_q;
  logic [PW-1:0] pair_q;
  logic          pair_end;

  assign valid    = active && (pair_q < pairs_done);
  assign fire     = valid && ready;
  assign pair_end = (idx_q == EW'(2 * N - 1));
  assign last     = fire && pair_end && (pair_q == PW'(N / 2 - 1));
  assign band     = irs_pkg::band_e'(idx_q[1:0]);
  assign col      = idx_q[EW-1:2];
  assign row      = HW'(pair_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      pair_q <= '0;
    end else if (clear) begin
      idx_q  <= '0;
      pair_q <= '0;
    end else if (fire) begin
      if (pair_end) begin
        idx_q  <= '0;
        pair_q <= pair_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irs_ctrl.sv
module irs_ctrl #(
  parameter  int N  = 16,
  localparam int AW = $clog2(N * N),
  localparam int BW = $clog2(4 * N),
  localparam int OW = $clog2(4 * N + 1),
  localparam int PW = $clog2(N / 2 + 1),
  localparam int HW = $clog2(N / 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_wide,
  input  logic          out_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr_a,
  output logic [AW-1:0] rd_addr_b,
  output logic [BW-1:0] buf_waddr,
  output logic [BW-1:0] buf_raddr,
  output logic          out_valid,
  output logic [1:0]    out_band,
  output logic [HW-1:0] out_row,
  output logic [HW-1:0] out_col,
  output logic          done
);
  // named internal events, brought out for the checker
  logic          busy_w, wide_w, start_acc_w, fetch_go_w, emit_go_w, last_w;
  logic          more_w, room_w;
  logic [PW-1:0] pairs_w;
  logic [OW-1:0] occ_w, depth_w;
  irs_pkg::band_e band_w;
  logic          done_q;

  assign start_acc_w = start && !busy_w;
  assign fetch_go_w  = busy_w && more_w && room_w && out_ready;
  assign rd_valid    = fetch_go_w;
  assign out_band    = band_w;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_w <= 1'b0;
      wide_w <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_w;
      if (start_acc_w) begin
        busy_w <= 1'b1;
        wide_w <= mode_wide;
      end else if (last_w) begin
        busy_w <= 1'b0;
      end
    end
  end

  irs_fetch_gen #(.N(N)) u_fetch (
    .clk(clk), .rst_n(rst_n), .clear(start_acc_w), .go(fetch_go_w),
    .more(more_w), .pairs_done(pairs_w),
    .addr_top(rd_addr_a), .addr_bot(rd_addr_b)
  );

  irs_tbuf_ptr #(.N(N)) u_tbuf (
    .clk(clk), .rst_n(rst_n), .clear(start_acc_w), .wide(wide_w),
    .push(fetch_go_w), .pop(emit_go_w),
    .wptr(buf_waddr), .rptr(buf_raddr), .occ(occ_w), .depth(depth_w),
    .room(room_w)
  );

  irs_emit_seq #(.N(N)) u_emit (
    .clk(clk), .rst_n(rst_n), .clear(start_acc_w), .active(busy_w),
    .pairs_done(pairs_w), .ready(out_ready),
    .valid(out_valid), .fire(emit_go_w), .last(last_w),
    .band(band_w), .row(out_row), .col(out_col)
  );
endmodule

// File: rtl/irs_ctrl_chk.sv
module irs_ctrl_chk #(
  parameter  int N  = 16,
  localparam int AW = $clog2(N * N),
  localparam int OW = $clog2(4 * N + 1),
  localparam int HW = $clog2(N / 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          out_ready,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr_a,
  input logic [AW-1:0] rd_addr_b,
  input logic          out_valid,
  input logic [1:0]    out_band,
  input logic [HW-1:0] out_row,
  input logic [HW-1:0] out_col,
  input logic          done,
  input logic          busy_w,
  input logic [OW-1:0] occ_w,
  input logic [OW-1:0] depth_w
);
  p_pair_stride_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(rd_addr_b) == int'(rd_addr_a) + N));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ_w <= depth_w);

  p_fetch_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> out_ready);

  p_hold_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_band) &&
                                    $stable(out_row) && $stable(out_col)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy_w && !rd_valid && !out_valid));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start) |=> (busy_w || done));
endmodule

bind irs_ctrl irs_ctrl_chk #(.N(N)) u_irs_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .out_ready(out_ready),
  .rd_valid(rd_valid), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
  .out_valid(out_valid), .out_band(out_band), .out_row(out_row),
  .out_col(out_col), .done(done), .busy_w(busy_w), .occ_w(occ_w),
  .depth_w(depth_w)
);

// File: tb/test_irs_ctrl.sv
module test_irs_ctrl;
  localparam int N  = 8;
  localparam int AW = $clog2(N * N);
  localparam int BW = $clog2(4 * N);
  localparam int HW = $clog2(N / 2);
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_wide = 1'b0, out_ready = 1'b1;
  logic rd_valid, out_valid, done;
  logic [AW-1:0] rd_addr_a, rd_addr_b;
  logic [BW-1:0] buf_waddr, buf_raddr;
  logic [1:0] out_band;
  logic [HW-1:0] out_row, out_col;

  always #10 clk = ~clk;

  irs_ctrl #(.N(N)) i_irs_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_wide(mode_wide),
    .out_ready(out_ready), .rd_valid(rd_valid), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .buf_waddr(buf_waddr), .buf_raddr(buf_raddr),
    .out_valid(out_valid), .out_band(out_band), .out_row(out_row),
    .out_col(out_col), .done(done)
  );

  int n_checks = 0, n_fail = 0;
  int fa_q[$], fb_q[$], out_q[$];
  int m_occ, m_wp, m_rp, m_depth, m_fetches;
  bit mon_en = 0, frame_done = 0, pend_done = 0, after_done = 0;
  bit held = 0;
  int held_band, held_row, held_col;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: expected fetches and output slots for one frame
  task automatic push_expected();
    for (int p = 0; p < N / 2; p++)
      for (int c = 0; c < N; c++) begin
        fa_q.push_back((2 * p) * N + c);
        fb_q.push_back((2 * p + 1) * N + c);
      end
    for (int p = 0; p < N / 2; p++)
      for (int k = 0; k < N / 2; k++)
        for (int b = 0; b < 4; b++)
          out_q.push_back((b << 16) | (p << 8) | k);
  endtask

  // monitor: samples between clock edges
  always @(negedge clk) begin
    if (mon_en) begin
      bit f, e;
      f = rd_valid;
      e = out_valid && out_ready;
      if (after_done) begin
        chk(!rd_valid && !out_valid, "R9 idle after done", rd_valid + out_valid, 0);
        after_done = 0;
      end
      chk(done == pend_done, "R9 done timing", done, pend_done);
      if (done) begin frame_done = 1; after_done = 1; end
      pend_done = 0;
      if (held) begin
        chk(out_valid && out_band == held_band && out_row == held_row && out_col == held_col,
            "R8 slot held", {out_band, out_row, out_col}, held_band);
      end
      if (f) begin
        chk(out_ready, "R8 no fetch while stalled", out_ready, 1);
        chk(m_occ + 2 <= m_depth, "R5 fetch needs room", m_occ, m_depth - 2);
        if (fa_q.size() == 0) chk(0, "R3 extra fetch", 1, 0);
        else begin
          int ea, eb;
          ea = fa_q.pop_front(); eb = fb_q.pop_front();
          chk(rd_addr_a == ea, "R2/R3 upper address", rd_addr_a, ea);
          chk(rd_addr_b == eb, "R2 lower address", rd_addr_b, eb);
        end
        chk(buf_waddr == m_wp, "R4 write pointer", buf_waddr, m_wp);
      end else if (out_ready && fa_q.size() > 0 && m_occ + 2 <= m_depth) begin
        chk(0, "R5 fetch withheld", 0, 1);
      end
      if (out_valid)
        chk(out_row < m_fetches / N, "R6 slot before pair complete", out_row, m_fetches / N);
      if (e) begin
        chk(buf_raddr == m_rp, "R4 read pointer", buf_raddr, m_rp);
        if (out_q.size() == 0) chk(0, "R7 extra output", 1, 0);
        else begin
          int x;
          x = out_q.pop_front();
          chk(out_band == x[17:16] && out_row == x[15:8] && out_col == x[7:0],
              "R7 slot order", {out_band, 6'(out_row), 8'(out_col)}, x);
          if (out_q.size() == 0) pend_done = 1;
        end
      end
      held = out_valid && !out_ready;
      held_band = out_band; held_row = out_row; held_col = out_col;
      if (f) begin
        m_wp = (m_wp + 2 == m_depth) ? 0 : m_wp + 2;
        m_fetches++;
      end
      if (e) m_rp = (m_rp + 1 == m_depth) ? 0 : m_rp + 1;
      m_occ = m_occ + (f ? 2 : 0) - (e ? 1 : 0);
      chk(m_occ <= m_depth, "R5 occupancy bound", m_occ, m_depth);
    end
  end

  task automatic run_frame(input bit wide, input int pat, input bit poke);
    int cyc;
    logic [15:0] lf;
    lf = 16'hACE1;
    @(posedge clk); #1;
    mode_wide = wide; start = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    m_depth = wide ? 4 * N : 2 * N;   // R11: depth fixed at start
    m_occ = 0; m_wp = 0; m_rp = 0; m_fetches = 0; frame_done = 0;
    push_expected();
    cyc = 0;
    while (!frame_done && cyc < LIMIT) begin
      case (pat)
        0: out_ready = 1'b1;
        1: begin lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]}; out_ready = lf[0] | lf[3]; end
        default: out_ready = (cyc % 5) >= 2;
      endcase
      if (poke && cyc == 20) begin start = 1'b1; mode_wide = ~wide; end  // R10, R11
      @(posedge clk); #1;
      start = 1'b0;
      cyc++;
    end
    if (!frame_done) chk(0, "R9 watchdog expired", cyc, LIMIT);
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(fa_q.size() == 0 && out_q.size() == 0, "R3 all items seen",
        fa_q.size() + out_q.size(), 0);
    fa_q.delete(); fb_q.delete(); out_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rd_valid && !out_valid && !done, "R1 reset state", rd_valid + out_valid + done, 0);
    #5 rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!rd_valid && !out_valid && !done, "R1 idle without start",
          rd_valid + out_valid + done, 0);
    end
    m_depth = 2 * N;
    mon_en = 1;
    run_frame(1'b0, 0, 1'b0);   // 5/3, ready always high
    run_frame(1'b1, 1, 1'b0);   // 9/7, irregular ready
    run_frame(1'b0, 2, 1'b1);   // 5/3, periodic stall, stray start, mode flip
    run_frame(1'b1, 0, 1'b1);   // 9/7, stray start, mode flip
    mon_en = 0;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule